// File: doc/BRIEF.md
# Ternary Ripple-Carry Adder

This block adds two unsigned ternary numbers of N digits each. Every digit (trit) travels on a pair of binary wires, so an operand is a packed vector of 2N bits. The result is an N-trit sum plus one extra carry trit, which acts as the most significant digit of the N+1-digit total.

The lowest digit position is a ternary half adder with no carry input. Each higher position is a ternary full adder. It takes its own operand trits and the carry trit produced by the position directly below. The carry therefore travels through every stage, and the datapath is purely combinational.

The two-bit pattern 11 has no digit meaning. A scan of both operands raises an error flag when any trit carries that pattern. While the flag is high, the whole result is forced to zero. The digit count is a parameter.

Top module: `tern_rca`

## Requirements
- R1: A trit is coded on two bits as 00 for 0, 01 for 1 and 10 for 2. Trit i of an operand or of the sum sits in bits [2i+1:2i], so trit 0 occupies bits [1:0].
- R2: The lowest sum trit equals (a0 + b0) mod 3, where a0 and b0 are the lowest operand trits. The carry that leaves position 0 equals floor((a0 + b0) / 3), and no carry enters position 0.
- R3: For every position i above 0, sum trit i equals (ai + bi + ci) mod 3. Here ci is the carry out of position i-1, and the carry out of position i is floor((ai + bi + ci) / 3).
- R4: The carry out of the top position is driven on carry_trit as code 00 or 01. A carry started at position 0 propagates through all N positions when every higher position sums to 2. For example, with N = 4, 2222 + 0001 gives sum 0000 and carry 1.
- R5: With valid operands, carry_trit * 3^N + value(sum_trits) equals value(a_trits) + value(b_trits).
- R6: bad_code is 1 exactly when at least one trit of either operand holds the code 11.
- R7: While bad_code is 1, sum_trits is all zeros and carry_trit is 00, whatever the other trits hold.
- R8: With valid operands, no sum trit carries the code 11 and carry_trit never carries 10 or 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_trits | input | 2*N_TRITS | First operand, trit 0 in bits [1:0] |
| b_trits | input | 2*N_TRITS | Second operand, same packing |
| sum_trits | output | 2*N_TRITS | Low N digits of the result |
| carry_trit | output | 2 | Top result digit (00 or 01) |
| bad_code | output | 1 | An operand trit holds the undefined code 11 |

## Verification
The hardest outcome to reach is a carry that starts at position 0 and crosses every stage. It needs every higher digit pair to sum to exactly 2, which few random operands satisfy. The default width has only 81 values per operand, so a full sweep of all 6561 valid pairs reaches every ripple length, including the full-length one. The error path is also awkward: code 11 has to appear at each single position of each operand while the other trits stay legal. A directed walk places 11 at every position in turn on top of nonzero legal operands.

// File: rtl/tern_pkg.sv
package tern_pkg;

  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_ZERO = 2'b00;
  localparam trit_t TRIT_ONE  = 2'b01;
  localparam trit_t TRIT_TWO  = 2'b10;
  localparam trit_t TRIT_BAD  = 2'b11;

  // One-hot digit decode: bit k set when the trit holds value k.
  // An undefined code decodes to all zeros.
  function automatic logic [2:0] trit_onehot(trit_t t);
    return {t == TRIT_TWO, t == TRIT_ONE, t == TRIT_ZERO};
  endfunction

  // One-hot sum of two one-hot digits: bit k set when x + y == k.
  function automatic logic [4:0] pair_spread(logic [2:0] x, logic [2:0] y);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < 3; i++) begin
      for (int j = 0; j < 3; j++) begin
        r[i+j] = r[i+j] | (x[i] & y[j]);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/tern_half_add.sv
module tern_half_add
  import tern_pkg::*;
(
  input  trit_t a_i,
  input  trit_t b_i,
  output trit_t sum_o,
  output trit_t carry_o
);

  logic [4:0] spread;

  always_comb begin
    spread  = pair_spread(trit_onehot(a_i), trit_onehot(b_i));
    // totals 0..4: digit = total mod 3, carry set for 3 and 4
    sum_o   = {spread[2], spread[1] | spread[4]};
    carry_o = {1'b0, spread[3] | spread[4]};
    if (a_i != TRIT_BAD && b_i != TRIT_BAD) begin
      assert_half_sum_R2: assert (int'(sum_o) + 3 * int'(carry_o) == int'(a_i) + int'(b_i))
        else $error("half adder digit/carry mismatch");
    end
  end

endmodule

// File: rtl/tern_full_add.sv
module tern_full_add
  import tern_pkg::*;
(
  input  trit_t a_i,
  input  trit_t b_i,
  input  trit_t cin_i,
  output trit_t sum_o,
  output trit_t carry_o
);

  logic [4:0] spread;
  logic [5:0] total;

  always_comb begin
    spread  = pair_spread(trit_onehot(a_i), trit_onehot(b_i));
    // an incoming carry of one shifts the one-hot total up by one place
    total   = (cin_i == TRIT_ONE) ? {spread, 1'b0} : {1'b0, spread};
    sum_o   = {total[2] | total[5], total[1] | total[4]};
    carry_o = {1'b0, total[3] | total[4] | total[5]};
    if (a_i != TRIT_BAD && b_i != TRIT_BAD && (cin_i == TRIT_ZERO || cin_i == TRIT_ONE)) begin
      assert_full_sum_R3: assert (int'(sum_o) + 3 * int'(carry_o)
                                  == int'(a_i) + int'(b_i) + int'(cin_i))
        else $error("full adder digit/carry mismatch");
    end
  end

endmodule

// File: rtl/tern_code_scan.sv
module tern_code_scan
  import tern_pkg::*;
#(
  parameter int N_TRITS = 4
) (
  input  logic [2*N_TRITS-1:0] a_i,
  input  logic [2*N_TRITS-1:0] b_i,
  output logic                 bad_o
);

  logic [N_TRITS-1:0] hit_a;
  logic [N_TRITS-1:0] hit_b;
  int                 bad_cnt;

  always_comb begin
    for (int i = 0; i < N_TRITS; i++) begin
      hit_a[i] = &a_i[2*i +: 2];
      hit_b[i] = &b_i[2*i +: 2];
    end
    bad_o = (|hit_a) | (|hit_b);

    bad_cnt = 0;
    for (int i = 0; i < N_TRITS; i++) begin
      if (a_i[2*i +: 2] == TRIT_BAD) bad_cnt++;
      if (b_i[2*i +: 2] == TRIT_BAD) bad_cnt++;
    end
    assert_flag_matches_R6: assert (bad_o == (bad_cnt != 0))
      else $error("undefined-code flag disagrees with trit count");
  end

endmodule

// File: rtl/tern_rca.sv
module tern_rca
  import tern_pkg::*;
#(
  parameter int N_TRITS = 4
) (
  input  logic [2*N_TRITS-1:0] a_trits,
  input  logic [2*N_TRITS-1:0] b_trits,
  output logic [2*N_TRITS-1:0] sum_trits,
  output logic [1:0]           carry_trit,
  output logic                 bad_code
);

  localparam int VEC_W = 2 * N_TRITS;

  trit_t            chain [1:N_TRITS];
  logic [VEC_W-1:0] raw_sum;
  logic             bad_in;

  tern_code_scan #(.N_TRITS(N_TRITS)) u_scan (
    .a_i   (a_trits),
    .b_i   (b_trits),
    .bad_o (bad_in)
  );

  for (genvar i = 0; i < N_TRITS; i++) begin : g_stage
    if (i == 0) begin : g_half
      tern_half_add u_add (
        .a_i     (a_trits[1:0]),
        .b_i     (b_trits[1:0]),
        .sum_o   (raw_sum[1:0]),
        .carry_o (chain[1])
      );
    end else begin : g_full
      tern_full_add u_add (
        .a_i     (a_trits[2*i +: 2]),
        .b_i     (b_trits[2*i +: 2]),
        .cin_i   (chain[i]),
        .sum_o   (raw_sum[2*i +: 2]),
        .carry_o (chain[i+1])
      );
    end
  end

  always_comb begin
    bad_code   = bad_in;
    sum_trits  = bad_in ? '0 : raw_sum;
    carry_trit = bad_in ? TRIT_ZERO : chain[N_TRITS];
  end

  // the digit stages must never emit an undefined code
  always_comb begin
    for (int i = 0; i < N_TRITS; i++) begin
      assert_digit_legal_R8: assert (raw_sum[2*i +: 2] != TRIT_BAD)
        else $error("stage emitted code 11");
    end
    assert_carry_legal_R4: assert (chain[N_TRITS][1] == 1'b0)
      else $error("top carry above one");
  end

endmodule

// File: tb/tern_rca_bench.sv
module tern_rca_bench;

  localparam int TRITS  = 4;
  localparam int W      = 2 * TRITS;
  localparam int SPAN   = 81;       // 3**TRITS
  localparam int PERIOD = 20;       // 50 MHz

  logic         clk = 1'b0;
  logic [W-1:0] a_trits = '0;
  logic [W-1:0] b_trits = '0;
  logic [W-1:0] sum_trits;
  logic [1:0]   carry_trit;
  logic         bad_code;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  tern_rca #(.N_TRITS(TRITS)) u_tern_rca (
    .a_trits    (a_trits),
    .b_trits    (b_trits),
    .sum_trits  (sum_trits),
    .carry_trit (carry_trit),
    .bad_code   (bad_code)
  );

  // base-3 encoding per R1: 0->00, 1->01, 2->10, trit 0 in bits [1:0]
  function automatic logic [W-1:0] enc(int v);
    logic [W-1:0] r;
    int           x;
    r = '0;
    x = v;
    for (int i = 0; i < TRITS; i++) begin
      r[2*i +: 2] = 2'(x % 3);
      x = x / 3;
    end
    return r;
  endfunction

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp, string what);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b);
    @(posedge clk);
    a_trits = a;
    b_trits = b;
    @(negedge clk);
  endtask

  task automatic check_valid(int x, int y);
    int           total;
    int           got_val;
    int           wt;
    logic [W-1:0] exp_sum;
    bit           legal;
    apply(enc(x), enc(y));
    total   = x + y;
    exp_sum = enc(total % SPAN);
    check("R6", W'(bad_code), W'(0), "flag on valid operands");
    check("R2", W'(sum_trits[1:0]), W'(exp_sum[1:0]), "lowest digit");
    check("R3", sum_trits, exp_sum, "digit vector");
    check("R4", W'(carry_trit), W'(total / SPAN), "top carry");
    legal   = (carry_trit[1] == 1'b0);
    got_val = 0;
    wt      = 1;
    for (int i = 0; i < TRITS; i++) begin
      if (sum_trits[2*i +: 2] == 2'b11) legal = 1'b0;
      got_val += wt * int'(sum_trits[2*i +: 2]);
      wt *= 3;
    end
    got_val += SPAN * int'(carry_trit);
    check("R8", W'(legal), W'(1), "codes legal");
    check("R5", W'(got_val), W'(total), "numeric total");
  endtask

  task automatic check_bad(logic [W-1:0] a, logic [W-1:0] b);
    apply(a, b);
    check("R6", W'(bad_code), W'(1), "flag on code 11");
    check("R7", sum_trits, '0, "forced zero sum");
    check("R7", W'(carry_trit), W'(0), "forced zero carry");
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // idle state with zero operands
    apply('0, '0);
    check("R5", sum_trits, '0, "idle sum");
    check("R4", W'(carry_trit), W'(0), "idle carry");
    check("R6", W'(bad_code), W'(0), "idle flag");

    // R1 packing: value 1 lands in bits [1:0], value 27 in bits [7:6]
    apply(W'(8'b00000001), '0);
    check("R1", sum_trits, W'(8'b00000001), "trit 0 placement");
    apply(W'(8'b01000000), W'(8'b01000000));
    check("R1", sum_trits, W'(8'b10000000), "trit 3 placement");

    // R4 full-length ripple: 2222 + 0001
    apply(W'(8'b10101010), W'(8'b00000001));
    check("R4", sum_trits, '0, "ripple sum");
    check("R4", W'(carry_trit), W'(1), "ripple carry");

    // exhaustive sweep of valid operand pairs
    for (int x = 0; x < SPAN; x++) begin
      for (int y = 0; y < SPAN; y++) begin
        check_valid(x, y);
      end
    end

    // walk code 11 through every position of each operand
    for (int p = 0; p < TRITS; p++) begin
      logic [W-1:0] base;
      base = enc(50);
      base[2*p +: 2] = 2'b11;
      check_bad(base, enc(79));
      check_bad(enc(80), base);
    end
    check_bad({W{1'b1}}, {W{1'b1}});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule